// File: doc/BRIEF.md
# Priority Memory Map Select Decoder

This block turns a core address into a single select for one of six destinations. The destinations are the debug window, the internal register block, RAM, EEPROM, on-chip flash and external space. The register block, RAM and EEPROM each sit at a base address set by its own relocation input, and RAM also has a size input. Because of this, any of these regions may overlap one another, the flash or the debug window. A fixed ranking settles every overlap, so exactly one destination wins.

The bus mode shapes the result. Single-chip mode leaves unclaimed addresses unselected. Expanded and peripheral modes route unclaimed addresses to external space. They also cut holes in the low end of the register block; an access to a hole leaves the chip as an emulated port access. A port-E enable widens the expanded-mode hole. External accesses are split across two chip selects: one for emulated port registers and one for general external space.

The decode itself is combinational. All outputs are registered once, so each result appears one clock after its inputs.

Top module: `mmap_sel_decode`

## Requirements
- R1: While `rst_n` is low, every output is 0. After reset, outputs show the decode of the inputs sampled at the previous rising clock edge.
- R2: `sel` bit positions are: 0 debug, 1 registers, 2 RAM, 3 EEPROM, 4 flash, 5 external. At most one `sel` bit is high. `emu_cs` and `ext_cs` are never both high, and `sel[5]` equals their OR.
- R3: When `dbg_en` is high, addresses 0xFF00–0xFFFF select debug, whatever other region also covers them.
- R4: The register block spans 1 KB starting at `{reg_base, 11'b0}`. It beats RAM, EEPROM and flash.
- R5: RAM starts at `{ram_base, 11'b0}` and spans 1 KB shifted left by `ram_sz` (0→1 KB, up to 3→8 KB). It beats EEPROM and flash.
- R6: EEPROM spans 2 KB starting at `{ee_base, 11'b0}`. It beats flash.
- R7: Flash covers 0x4000–0xFFFF and ranks lowest among the internal regions.
- R8: `mode` encodings are: 0 single-chip, 1 expanded, 2 peripheral, 3 reserved. For an address no region claims, modes 1 and 2 raise `sel[5]` with `ext_cs`, and modes 0 and 3 raise nothing.
- R9: In mode 1, a register-block win at offsets 0x0–0x3 selects external with `emu_cs`. When `pe_ext_en` is high, offsets 0x8 and 0x9 do the same. In every other mode except 2, these offsets select registers.
- R10: In mode 2, a register-block win at offsets 0x0–0xF selects external with `emu_cs`. Offset 0x10 and above still select registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Core address |
| mode | input | 2 | Bus mode (see R8) |
| dbg_en | input | 1 | Enables the debug window |
| pe_ext_en | input | 1 | Moves port-E registers external in expanded mode |
| reg_base | input | 5 | Register block base, 2 KB units |
| ram_base | input | 5 | RAM base, 2 KB units |
| ram_sz | input | 2 | RAM size code |
| ee_base | input | 5 | EEPROM base, 2 KB units |
| sel | output | 6 | One-hot destination select |
| emu_cs | output | 1 | Emulated port-register chip select |
| ext_cs | output | 1 | General external chip select |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 2 KB base alignment, a 1 KB register block, 2 KB EEPROM and flash from 0x4000. With these values, 5-bit bases drawn from a small set often stack the register block, RAM, EEPROM, flash and the debug window on the same bytes. Both ends of the RAM size range and every bus mode, including the reserved one, can be reached within a few thousand cycles. Addresses are steered toward region bases and hole offsets, so that the priority ranking and every hole edge are tested against the bench's own model on each clock.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  localparam int unsigned NSEL = 6;
  localparam int unsigned NINT = 5;

  typedef enum logic [2:0] {
    SEL_DBG   = 3'd0,
    SEL_REG   = 3'd1,
    SEL_RAM   = 3'd2,
    SEL_EE    = 3'd3,
    SEL_FLASH = 3'd4,
    SEL_EXT   = 3'd5
  } sel_idx_e;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_EXPAND = 2'd1,
    MODE_PERIPH = 2'd2,
    MODE_RSVD   = 2'd3
  } bus_mode_e;

endpackage

// File: rtl/mmap_window.sv
// Address window match: hit when base <= addr < base + span.
module mmap_window #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   span,
  output logic              hit
);
  logic [ADDR_W:0] diff;

  always_comb begin
    diff = {1'b0, addr} - {1'b0, base};
    hit  = !diff[ADDR_W] && (diff < span);
  end
endmodule

// File: rtl/mmap_reg_hole.sv
// Register offsets that leave the internal map for the current bus mode.
module mmap_reg_hole
  import mmap_pkg::*;
#(
  parameter int unsigned OFF_W      = 10,
  parameter int unsigned EXP_CNT    = 4,
  parameter int unsigned PERIPH_CNT = 16,
  parameter int unsigned PE_OFF_A   = 8,
  parameter int unsigned PE_OFF_B   = 9
) (
  input  logic [OFF_W-1:0] off,
  input  bus_mode_e        mode,
  input  logic             pe_ext_en,
  output logic             hole
);
  logic low_exp, low_per, pe_hit;

  always_comb begin
    low_exp = off < OFF_W'(EXP_CNT);
    low_per = off < OFF_W'(PERIPH_CNT);
    pe_hit  = pe_ext_en && ((off == OFF_W'(PE_OFF_A)) || (off == OFF_W'(PE_OFF_B)));
    unique case (mode)
      MODE_EXPAND: hole = low_exp || pe_hit;
      MODE_PERIPH: hole = low_per;
      default:     hole = 1'b0;
    endcase
  end
endmodule

// File: rtl/mmap_prio.sv
// Fixed-priority pick, index 0 highest.
module mmap_prio #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         none
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign gnt[i]     = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end

  assign none = ~taken[N];
endmodule

// File: rtl/mmap_sel_decode.sv
module mmap_sel_decode
  import mmap_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned ALIGN_LOG2    = 11,
  parameter int unsigned REG_SIZE_LOG2 = 10,
  parameter int unsigned EE_SIZE_LOG2  = 11,
  parameter int unsigned RAM_MIN_LOG2  = 10,
  parameter int unsigned DBG_LOG2      = 8,
  parameter int unsigned FLASH_LO      = 16'h4000,
  parameter int unsigned SZ_W          = 2,
  localparam int unsigned BASE_W       = ADDR_W - ALIGN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        mode,
  input  logic              dbg_en,
  input  logic              pe_ext_en,
  input  logic [BASE_W-1:0] reg_base,
  input  logic [BASE_W-1:0] ram_base,
  input  logic [SZ_W-1:0]   ram_sz,
  input  logic [BASE_W-1:0] ee_base,
  output logic [NSEL-1:0]   sel,
  output logic              emu_cs,
  output logic              ext_cs
);
  localparam logic [ADDR_W:0]   ONE       = (ADDR_W+1)'(1);
  localparam logic [ADDR_W:0]   SPAN_ALL  = ONE << ADDR_W;
  localparam logic [ADDR_W:0]   DBG_SPAN  = ONE << DBG_LOG2;
  localparam logic [ADDR_W:0]   REG_SPAN  = ONE << REG_SIZE_LOG2;
  localparam logic [ADDR_W:0]   EE_SPAN   = ONE << EE_SIZE_LOG2;
  localparam logic [ADDR_W:0]   RAM_SPAN0 = ONE << RAM_MIN_LOG2;
  localparam logic [ADDR_W:0]   FL_LO_X   = (ADDR_W+1)'(FLASH_LO);
  localparam logic [ADDR_W:0]   FL_SPAN   = SPAN_ALL - FL_LO_X;
  localparam logic [ADDR_W-1:0] DBG_BASE  = ADDR_W'(SPAN_ALL - DBG_SPAN);
  localparam logic [ADDR_W-1:0] FL_BASE   = ADDR_W'(FLASH_LO);

  bus_mode_e         bmode;
  logic [ADDR_W-1:0] base_a [NINT];
  logic [ADDR_W:0]   span_a [NINT];
  logic [NINT-1:0]   hit, req, gnt;
  logic              none, hole;

  logic [NSEL-1:0]   sel_d, sel_q;
  logic              emu_d, emu_q, ext_d, ext_q;

  assign bmode = bus_mode_e'(mode);

  // Region table
  always_comb begin
    base_a[SEL_DBG]   = DBG_BASE;
    span_a[SEL_DBG]   = DBG_SPAN;
    base_a[SEL_REG]   = {reg_base, {ALIGN_LOG2{1'b0}}};
    span_a[SEL_REG]   = REG_SPAN;
    base_a[SEL_RAM]   = {ram_base, {ALIGN_LOG2{1'b0}}};
    span_a[SEL_RAM]   = RAM_SPAN0 << ram_sz;
    base_a[SEL_EE]    = {ee_base, {ALIGN_LOG2{1'b0}}};
    span_a[SEL_EE]    = EE_SPAN;
    base_a[SEL_FLASH] = FL_BASE;
    span_a[SEL_FLASH] = FL_SPAN;
  end

  for (genvar i = 0; i < NINT; i++) begin : g_win
    mmap_window #(.ADDR_W(ADDR_W)) u_win (
      .addr (addr),
      .base (base_a[i]),
      .span (span_a[i]),
      .hit  (hit[i])
    );
    if (i == int'(SEL_DBG)) begin : g_gate
      assign req[i] = hit[i] & dbg_en;
    end else begin : g_pass
      assign req[i] = hit[i];
    end
  end

  mmap_prio #(.N(NINT)) u_prio (
    .req  (req),
    .gnt  (gnt),
    .none (none)
  );

  // Register base is aligned above its size, so the offset is the low bits.
  mmap_reg_hole #(.OFF_W(REG_SIZE_LOG2)) u_hole (
    .off       (addr[REG_SIZE_LOG2-1:0]),
    .mode      (bmode),
    .pe_ext_en (pe_ext_en),
    .hole      (hole)
  );

  // Next-state
  always_comb begin
    emu_d = gnt[SEL_REG] & hole;
    ext_d = none & ((bmode == MODE_EXPAND) || (bmode == MODE_PERIPH));
    sel_d = '0;
    for (int i = 0; i < int'(NINT); i++) begin
      sel_d[i] = gnt[i];
    end
    sel_d[SEL_REG] = gnt[SEL_REG] & ~hole;
    sel_d[SEL_EXT] = emu_d | ext_d;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      emu_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      emu_q <= emu_d;
      ext_q <= ext_d;
    end
  end

  assign sel    = sel_q;
  assign emu_cs = emu_q;
  assign ext_cs = ext_q;

  // Checks
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));

  p_cs_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[SEL_EXT] == (emu_q | ext_q)) && !(emu_q && ext_q));

  p_dbg_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_en && (&addr[ADDR_W-1:DBG_LOG2])) |=> sel_q[SEL_DBG]);

  p_reg_over_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd0) && !dbg_en && (addr[ADDR_W-1:ALIGN_LOG2] == reg_base)
     && (addr[ALIGN_LOG2-1:REG_SIZE_LOG2] == '0)) |=> sel_q[SEL_REG]);

  p_single_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (!sel_q[SEL_EXT] && !emu_q && !ext_q));

endmodule

// File: tb/tb_mmap_sel_decode.sv
module tb_mmap_sel_decode;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [1:0]  mode;
  logic        dbg_en, pe_ext_en;
  logic [4:0]  reg_base, ram_base, ee_base;
  logic [1:0]  ram_sz;
  logic [5:0]  sel;
  logic        emu_cs, ext_cs;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  logic [7:0] exp_v;

  always #5 clk = ~clk;

  mmap_sel_decode dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mode(mode), .dbg_en(dbg_en),
    .pe_ext_en(pe_ext_en), .reg_base(reg_base), .ram_base(ram_base),
    .ram_sz(ram_sz), .ee_base(ee_base), .sel(sel), .emu_cs(emu_cs),
    .ext_cs(ext_cs)
  );

  // Behavioural model: result = {ext_cs, emu_cs, sel[5:0]}
  function automatic logic [7:0] model();
    int a, rb, mb, msz, eb, off;
    bit hole;
    a   = int'(addr);
    rb  = int'(reg_base) * 2048;
    mb  = int'(ram_base) * 2048;
    msz = 1024 << ram_sz;
    eb  = int'(ee_base) * 2048;
    if (dbg_en && a >= 'hFF00) return 8'h01;
    if (a >= rb && a < rb + 1024) begin
      off  = a - rb;
      hole = (mode == 2 && off < 16) ||
             (mode == 1 && (off < 4 || (pe_ext_en && (off == 8 || off == 9))));
      return hole ? 8'h60 : 8'h02;
    end
    if (a >= mb && a < mb + msz) return 8'h04;
    if (a >= eb && a < eb + 2048) return 8'h08;
    if (a >= 'h4000) return 8'h10;
    if (mode == 1 || mode == 2) return 8'hA0;
    return 8'h00;
  endfunction

  function automatic string tag_of(logic [7:0] v, logic [1:0] m);
    case (v)
      8'h01: return "R3";
      8'h02: return "R4";
      8'h04: return "R5";
      8'h08: return "R6";
      8'h10: return "R7";
      8'h60: return (m == 2) ? "R10" : "R9";
      default: return "R8";
    endcase
  endfunction

  logic [1:0] exp_mode;

  task automatic check_now();
    logic [7:0] act;
    act = {ext_cs, emu_cs, sel};
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s addr-cycle actual=%h expected=%h", tag_of(exp_v, exp_mode), act, exp_v);
    end
    total++;
    if (!$onehot0(sel) || (emu_cs && ext_cs) || (sel[5] !== (emu_cs | ext_cs))) begin
      bad++;
      $display("FAIL R2 exclusivity actual=%h expected=one-hot", act);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [1:0] m, input bit d,
                       input bit pe, input logic [4:0] rb, input logic [4:0] mb,
                       input logic [1:0] rs, input logic [4:0] eb);
    @(negedge clk);
    check_now();
    addr = a; mode = m; dbg_en = d; pe_ext_en = pe;
    reg_base = rb; ram_base = mb; ram_sz = rs; ee_base = eb;
    exp_v = model();
    exp_mode = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    addr = 16'h0810; mode = 2'd1; dbg_en = 1'b0; pe_ext_en = 1'b0;
    reg_base = 5'd1; ram_base = 5'd1; ram_sz = 2'd0; ee_base = 5'd3;
    repeat (3) @(negedge clk);
    total++;
    if ({ext_cs, emu_cs, sel} !== 8'h00) begin
      bad++;
      $display("FAIL R1 reset actual=%h expected=00", {ext_cs, emu_cs, sel});
    end
    rst_n = 1'b1;
    exp_v = model();
    exp_mode = mode;

    // R3: debug over RAM and flash
    apply(16'hFF10, 2'd0, 1, 0, 5'd31, 5'd31, 2'd3, 5'd3);
    // R5: debug off, RAM wins over flash
    apply(16'hFF10, 2'd0, 0, 0, 5'd31, 5'd31, 2'd3, 5'd3);
    // R4: registers over RAM
    apply(16'h0810, 2'd0, 0, 0, 5'd1, 5'd1, 2'd3, 5'd1);
    apply(16'h0802, 2'd0, 0, 0, 5'd1, 5'd1, 2'd3, 5'd1);
    // R9: expanded holes
    apply(16'h0802, 2'd1, 0, 0, 5'd1, 5'd1, 2'd3, 5'd1);
    apply(16'h0804, 2'd1, 0, 0, 5'd1, 5'd1, 2'd3, 5'd1);
    apply(16'h0808, 2'd1, 0, 0, 5'd1, 5'd1, 2'd3, 5'd1);
    apply(16'h0808, 2'd1, 0, 1, 5'd1, 5'd1, 2'd3, 5'd1);
    apply(16'h0809, 2'd1, 0, 1, 5'd1, 5'd1, 2'd3, 5'd1);
    apply(16'h080A, 2'd1, 0, 1, 5'd1, 5'd1, 2'd3, 5'd1);
    // R10: peripheral holes
    apply(16'h080F, 2'd2, 0, 0, 5'd1, 5'd1, 2'd3, 5'd1);
    apply(16'h0810, 2'd2, 0, 0, 5'd1, 5'd1, 2'd3, 5'd1);
    apply(16'h0800, 2'd3, 0, 1, 5'd1, 5'd1, 2'd3, 5'd1);
    // R5: RAM size edges; R8: unclaimed per mode
    apply(16'h13FF, 2'd0, 0, 0, 5'd0, 5'd2, 2'd0, 5'd7);
    apply(16'h1400, 2'd0, 0, 0, 5'd0, 5'd2, 2'd0, 5'd7);
    apply(16'h1400, 2'd1, 0, 0, 5'd0, 5'd2, 2'd0, 5'd7);
    apply(16'h1400, 2'd3, 0, 0, 5'd0, 5'd2, 2'd0, 5'd7);
    apply(16'h1FFF, 2'd0, 0, 0, 5'd0, 5'd2, 2'd2, 5'd7);
    apply(16'h2000, 2'd2, 0, 0, 5'd0, 5'd2, 2'd2, 5'd7);
    // R6: EEPROM under RAM, then alone
    apply(16'h1900, 2'd0, 0, 0, 5'd0, 5'd2, 2'd2, 5'd3);
    apply(16'h1FFF, 2'd0, 0, 0, 5'd0, 5'd2, 2'd0, 5'd3);
    apply(16'h5000, 2'd0, 0, 0, 5'd0, 5'd2, 2'd0, 5'd10);
    // R7: flash edges
    apply(16'h4000, 2'd0, 0, 0, 5'd0, 5'd2, 2'd0, 5'd3);
    apply(16'h3FFF, 2'd0, 0, 0, 5'd0, 5'd2, 2'd0, 5'd3);
    apply(16'hFFFF, 2'd1, 0, 0, 5'd0, 5'd2, 2'd0, 5'd3);

    // Randomized overlapping maps
    for (int n = 0; n < 4000; n++) begin
      logic [4:0]  rb, mb, eb;
      logic [15:0] a;
      int          pick;
      rb = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 3));
      mb = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 3));
      eb = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 3));
      pick = $urandom_range(0, 4);
      case (pick)
        0: a = {rb, 11'd0} + 16'($urandom_range(0, 20));
        1: a = {mb, 11'd0} + 16'($urandom_range(0, 8191));
        2: a = 16'hFF00 + 16'($urandom_range(0, 255));
        3: a = {eb, 11'd0} + 16'($urandom_range(0, 2100));
        default: a = 16'($urandom);
      endcase
      apply(a, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
            rb, mb, 2'($urandom_range(0, 3)), eb);
    end
    @(negedge clk);
    check_now();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule